// File: doc/BRIEF.md
# Streaming Vector Reduction Unit

The block folds a vector of words into a single value with one pipelined arithmetic unit of fixed latency. A reduction begins with a one-cycle `start` pulse that carries the element count. The elements then arrive on `in_valid`/`in_data` at up to one per clock, and the block never stalls them. Because the unit needs `LAT` cycles per operation, the block keeps up to `LAT` independent partial results circulating in the pipeline. Each arriving element is combined with whichever partial leaves the pipeline in that cycle.

Once the counted elements have all been taken, the block enters a folding phase. Partials that leave the pipeline are paired and fed back in until only one remains. That value is then presented on `res_data`, and `res_valid` pulses for one cycle. The parameter `OP_KIND` selects the operator: 0 gives a wrapping sum and 1 gives a wrapping product. Integer arithmetic stands in for floating point, so the scheduling can be checked exactly.

Top module: `acc_vec_reduce`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is 0 and `res_data` is 0.
- R2: With `OP_KIND`=0, the result equals the sum of the `elem_count` accepted elements, modulo 2^`DATA_W`.
- R3: An element is accepted in every cycle in which `in_valid` is high during a reduction, with no stall cycles. No more than `LAT` operations are ever in flight.
- R4: Cycles with `in_valid` low during a reduction are skipped, not counted. The reduction continues until `elem_count` elements have been accepted.
- R5: `res_valid` is high for exactly one cycle per reduction. `res_data` keeps its value until the next result.
- R6: A vector of one element returns that element unchanged.
- R7: When `elem_count` is 0, the cycle after the `start` edge shows `res_valid` high, with the operator's identity value (0 for sum, 1 for product).
- R8: `start` is ignored while a reduction is busy. Busy means from the accepted `start` through the cycle in which `res_valid` is high.
- R9: `in_valid` outside a reduction is ignored. It neither produces a result nor changes the next one.
- R10: The result appears no more than 6*`LAT` cycles after the last element is accepted.
- R11: With `OP_KIND`=1, the result equals the product of the accepted elements, modulo 2^`DATA_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a reduction when idle |
| elem_count | input | CNT_W | Number of elements in the vector, sampled with `start` |
| in_valid | input | 1 | Element present on `in_data` |
| in_data | input | DATA_W | Element value |
| res_valid | output | 1 | One-cycle pulse marking the result |
| res_data | output | DATA_W | Reduced value |

## Verification
The hardest case to reach from the ports is the folding phase when it starts with a full pipeline of `LAT` partials. The hardest variant is a full pipeline mixed with gaps, so that the partial slots hold uneven element counts when folding begins. The stimulus table includes vectors longer than `LAT`, and it injects idle cycles between elements. This shifts which slot each element joins. Every result is checked against both a sum instance and a product instance, so a lost or doubly-counted partial shows up in at least one of them.

// File: rtl/acc_pkg.sv
// Shared definitions for the vector reduction unit.
// Assumes: nothing beyond IEEE 1800-2017.
package acc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_FOLD   = 2'd2
    } acc_state_e;

    localparam int OP_SUM  = 0;
    localparam int OP_PROD = 1;
endpackage

// File: rtl/acc_op_unit.sv
// Combinational two-operand operator, chosen by OP_KIND.
// Assumes: wrapping integer arithmetic at DATA_W bits.
module acc_op_unit #(
    parameter int DATA_W  = 32,
    parameter int OP_KIND = 0
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    generate
        if (OP_KIND == acc_pkg::OP_PROD) begin : g_prod
            // product, truncated to DATA_W bits
            always_comb y = a * b;
        end else begin : g_sum
            // sum, wrapping at DATA_W bits
            always_comb y = a + b;
        end
    endgenerate
endmodule

// File: rtl/acc_pipe.sv
// Delay line of LAT registered stages modelling the arithmetic pipeline.
// Assumes: LAT >= 1. An entry issued in cycle t leaves in cycle t+LAT.
module acc_pipe #(
    parameter int DATA_W = 32,
    parameter int LAT    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic [DATA_W-1:0] in_d,
    output logic              out_v,
    output logic [DATA_W-1:0] out_d
);
    logic [LAT-1:0]    v;
    logic [DATA_W-1:0] d [LAT];

    generate
        for (genvar s = 0; s < LAT; s++) begin : g_stage
            if (s == 0) begin : g_head
                // first stage captures the operator output
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v[0] <= 1'b0;
                        d[0] <= '0;
                    end else begin
                        v[0] <= in_v;
                        d[0] <= in_d;
                    end
                end
            end else begin : g_body
                // later stages shift the entry forward by one
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v[s] <= 1'b0;
                        d[s] <= '0;
                    end else begin
                        v[s] <= v[s-1];
                        d[s] <= d[s-1];
                    end
                end
            end
        end
    endgenerate

    assign out_v = v[LAT-1];
    assign out_d = d[LAT-1];
endmodule

// File: rtl/acc_vec_reduce.sv
// Streaming reduction of a counted vector to one value.
// Keeps up to LAT interleaved partials in the pipeline while streaming.
// Afterwards it pairs the partials that leave the pipeline until one remains.
// Assumes: start is a pulse, elem_count is sampled with it, and the operator
// is commutative and associative.
module acc_vec_reduce #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int LAT     = 8,
    parameter int OP_KIND = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  elem_count,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    import acc_pkg::*;

    localparam int INF_W = $clog2(LAT + 1);
    localparam logic [DATA_W-1:0] IDENT =
        (OP_KIND == OP_PROD) ? DATA_W'(1) : '0;

    acc_state_e        state;
    logic [CNT_W-1:0]  tgt_cnt;
    logic [CNT_W-1:0]  acc_cnt;
    logic              hold_v;
    logic [DATA_W-1:0] hold_d;
    logic [INF_W-1:0]  inflight;
    logic              pipe_ov;
    logic [DATA_W-1:0] pipe_od;
    logic              iss_v;
    logic [DATA_W-1:0] iss_a;
    logic [DATA_W-1:0] iss_b;
    logic [DATA_W-1:0] op_y;
    logic              take;
    logic              busy;
    logic              finish;

    assign busy   = (state != ST_IDLE) || res_valid;
    assign take   = (state == ST_STREAM) && in_valid;
    assign finish = (state == ST_FOLD) && hold_v && (inflight == '0);

    // choose the operand pair issued into the pipeline this cycle
    always_comb begin
        iss_v = 1'b0;
        iss_a = IDENT;
        iss_b = IDENT;
        if (state == ST_STREAM) begin
            if (pipe_ov) begin
                iss_v = 1'b1;
                iss_a = pipe_od;
                iss_b = take ? in_data : IDENT;
            end else if (take) begin
                iss_v = 1'b1;
                iss_a = in_data;
            end
        end else if (state == ST_FOLD) begin
            if (pipe_ov && hold_v) begin
                iss_v = 1'b1;
                iss_a = hold_d;
                iss_b = pipe_od;
            end
        end
    end

    acc_op_unit #(.DATA_W(DATA_W), .OP_KIND(OP_KIND)) u_op (
        .a (iss_a),
        .b (iss_b),
        .y (op_y)
    );

    acc_pipe #(.DATA_W(DATA_W), .LAT(LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (iss_v),
        .in_d  (op_y),
        .out_v (pipe_ov),
        .out_d (pipe_od)
    );

    // track how many entries are inside the pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + INF_W'(iss_v) - INF_W'(pipe_ov);
    end

    // phase control, element counting, fold holding register and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tgt_cnt   <= '0;
            acc_cnt   <= '0;
            hold_v    <= 1'b0;
            hold_d    <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && !res_valid) begin
                        tgt_cnt <= elem_count;
                        acc_cnt <= '0;
                        hold_v  <= 1'b0;
                        if (elem_count == '0) begin
                            res_valid <= 1'b1;
                            res_data  <= IDENT;
                        end else begin
                            state <= ST_STREAM;
                        end
                    end
                end
                ST_STREAM: begin
                    if (take) begin
                        acc_cnt <= acc_cnt + 1'b1;
                        if (acc_cnt + 1'b1 == tgt_cnt) state <= ST_FOLD;
                    end
                end
                ST_FOLD: begin
                    if (finish) begin
                        res_valid <= 1'b1;
                        res_data  <= hold_d;
                        hold_v    <= 1'b0;
                        state     <= ST_IDLE;
                    end else if (pipe_ov) begin
                        if (hold_v) begin
                            hold_v <= 1'b0;
                        end else begin
                            hold_v <= 1'b1;
                            hold_d <= pipe_od;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= INF_W'(LAT));

    // R5
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tgt_cnt));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (acc_cnt <= tgt_cnt));

    // R9
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (inflight == '0 && !pipe_ov));
endmodule

// File: tb/acc_vec_reduce_test.sv
module acc_vec_reduce_test;
    localparam int DW  = 32;
    localparam int CW  = 16;
    localparam int LAT = 8;
    localparam int NV  = 6;
    localparam int MAXL = 12;

    localparam int VLEN [NV] = '{5, 8, 9, 12, 2, 12};
    localparam bit VGAP [NV] = '{0, 0, 1, 0, 1, 1};
    localparam logic [DW-1:0] VTBL [NV][MAXL] = '{
        '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 0, 0, 0, 0, 0, 0, 0},
        '{32'd10, 32'd20, 32'd30, 32'd40, 32'd50, 32'd60, 32'd70, 32'd80, 0, 0, 0, 0},
        '{32'd3, 32'd5, 32'd7, 32'd11, 32'd13, 32'd17, 32'd19, 32'd23, 32'd29, 0, 0, 0},
        '{32'h8000_0000, 32'h8000_0001, 32'd7, 32'hFFFF_FFF0, 32'd9, 32'd3,
          32'd1234, 32'd5, 32'h0001_0000, 32'd2, 32'd77, 32'd6},
        '{32'hFFFF_FFFF, 32'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
        '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6, 32'd7, 32'd8, 32'd9, 32'd10, 32'd11, 32'd12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] elem_count = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          sum_v, prod_v;
    logic [DW-1:0] sum_d, prod_d;

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;
    logic [DW-1:0] vbuf [MAXL];

    always #10 clk = ~clk;

    acc_vec_reduce #(.DATA_W(DW), .CNT_W(CW), .LAT(LAT), .OP_KIND(0)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_count(elem_count),
        .in_valid(in_valid), .in_data(in_data),
        .res_valid(sum_v), .res_data(sum_d));

    acc_vec_reduce #(.DATA_W(DW), .CNT_W(CW), .LAT(LAT), .OP_KIND(1)) uut_prod (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_count(elem_count),
        .in_valid(in_valid), .in_data(in_data),
        .res_valid(prod_v), .res_data(prod_d));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // stream vbuf[0..len-1]; optional gaps and a stray start mid-stream
    task automatic run_vec(input int len, input bit gap, input bit stray, input string tag);
        logic [DW-1:0] es = '0;
        logic [DW-1:0] ep = 32'd1;
        int wait_c = 0;
        for (int i = 0; i < len; i++) begin
            es = es + vbuf[i];
            ep = ep * vbuf[i];
        end
        @(negedge clk);
        start = 1'b1;
        elem_count = CW'(len);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (gap && (i % 2 == 1)) begin
                in_valid = 1'b0;
                in_data = 32'h5A5A_5A5A;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data = vbuf[i];
            if (stray && i == 2) begin
                start = 1'b1;
                elem_count = CW'(1);
            end
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        while (!sum_v && wait_c < 200) begin
            @(negedge clk);
            wait_c++;
        end
        // R10 latency bound after the last element
        n_chk++;
        if (wait_c > 6 * LAT) begin
            n_fail++;
            $display("FAIL R10 %s: actual %0d cycles expected <= %0d", tag, wait_c, 6 * LAT);
        end
        chk({"R2/R3/R4 sum ", tag}, sum_d, es);
        chk({"R11 product ", tag}, prod_d, ep);
        @(negedge clk);
        chk({"R5 pulse ", tag}, {31'd0, sum_v}, 32'd0);
        chk({"R5 hold ", tag}, sum_d, es);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'd0, sum_v}, 32'd0);
        chk("R1 data", sum_d, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table-driven vectors
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < MAXL; i++) vbuf[i] = VTBL[v][i];
            run_vec(VLEN[v], VGAP[v], 1'b0, $sformatf("vec%0d", v));
        end

        // R6 single element
        vbuf[0] = 32'hDEAD_BEEF;
        run_vec(1, 1'b0, 1'b0, "len1");
        chk("R6 single", sum_d, 32'hDEAD_BEEF);

        // R7 zero length
        @(negedge clk);
        start = 1'b1;
        elem_count = '0;
        @(negedge clk);
        start = 1'b0;
        chk("R7 valid", {31'd0, sum_v}, 32'd1);
        chk("R7 sum ident", sum_d, 32'd0);
        chk("R7 prod ident", prod_d, 32'd1);
        @(negedge clk);
        chk("R5 zero-len pulse", {31'd0, sum_v}, 32'd0);

        // R9 stray elements while idle
        in_valid = 1'b1;
        in_data = 32'd999;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 no result", {31'd0, sum_v}, 32'd0);
        end
        in_valid = 1'b0;
        vbuf[0] = 32'd4;
        vbuf[1] = 32'd6;
        run_vec(2, 1'b0, 1'b0, "after-idle");
        chk("R9 sum", sum_d, 32'd10);

        // R8 start during a reduction is ignored
        for (int i = 0; i < 10; i++) vbuf[i] = DW'(i * 7 + 3);
        run_vec(10, 1'b0, 1'b1, "stray-start");
        chk("R8 sum", sum_d, 32'd345);
        repeat (LAT * 2) @(negedge clk);
        chk("R8 no extra result", {31'd0, sum_v}, 32'd0);

        finish_run();
    end
endmodule